// File: doc/BRIEF.md
# Thermal Event Assertion Timer

This block watches an active-low thermal-event input and keeps a running total of how long that input has been held asserted. Time is measured in whole quanta: a timebase pulse `tick_i` marks each quantum, which is about 22.76 ms in a typical system. While the timer is enabled, every tick that lands while the synchronised input is asserted adds one to the total. A programmable limit compares against that total and raises a level alert. A limit of zero changes the meaning of the alert: it then fires on the first enabled assertion and does not wait for time to accumulate. Host logic reads the total through a read strobe, and the read clears the total.

The block also has a fail-safe cooling path. When the boost control is set, every fan whose incoming duty is non-zero is driven to full duty for as long as the synchronised input stays asserted. A fan that is stopped (duty zero) is never started by this path. When boost is clear, the duty values pass through unchanged.

None of the interfaces carries a data stream. Configuration, readback and fan duty are plain level signals that are sampled or driven every cycle, so there is no valid/ready handshake and no back-pressure.

Top module: `therm_tally_top`

## Requirements
- R1: After reset the accumulated total reads 0, the alert is low, and every fan duty passes through unchanged, because the synchroniser resets to the deasserted level.
- R2: The thermal input goes through two flip-flops. A level applied before a rising edge takes effect on the internal asserted state after the second rising edge.
- R3: While `cfg_en_i` is 1, each cycle with `tick_i` high and the synchronised input asserted (low) adds exactly one to the total. While `cfg_en_i` is 0 the total does not change except by a read.
- R4: The total saturates at 2^ACC_W-1 and never wraps.
- R5: `rd_data_o` always shows the current total. A cycle with `rd_req_i` high clears the total and the first-event flag on the next edge. A read overrides a tick in the same cycle.
- R6: With a non-zero limit and the mask clear, `alert_o` is 1 exactly when the total is strictly greater than the limit.
- R7: With a limit of 0 and the mask clear, `alert_o` is 1 from the edge after the first cycle in which the timer is enabled and the synchronised input is asserted. It stays 1 until a read clears it.
- R8: While `cfg_mask_i` is 1, `alert_o` is 0. The alert is a level and is not latched apart from the stored state.
- R9: With `cfg_boost_i` set and the synchronised input asserted, each fan whose input duty is non-zero outputs all ones.
- R10: A fan with input duty 0 always outputs 0. With boost clear or the input deasserted, each output duty equals its input duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_n_i | input | 1 | Asynchronous active-low thermal event |
| tick_i | input | 1 | One-cycle pulse per time quantum |
| cfg_en_i | input | 1 | Timer enable |
| cfg_mask_i | input | 1 | Alert suppression |
| cfg_boost_i | input | 1 | Full-duty override enable |
| limit_i | input | ACC_W | Alert limit in quanta (0 = first event) |
| rd_req_i | input | 1 | Read strobe; clears the total |
| rd_data_o | output | ACC_W | Current accumulated total |
| alert_o | output | 1 | Level alert |
| duty_in_i | input | NUM_FANS*DUTY_W | Requested fan duties, fan 0 in the low bits |
| duty_out_o | output | NUM_FANS*DUTY_W | Applied fan duties |

## Verification
The assertions take for granted that the reset is released synchronously to the clock, and that the configuration and limit only change between edges. They do not depend on any tick spacing, so a tick on every cycle is legal. The stimulus changes all inputs only on falling edges. It holds the thermal input for random run lengths so that both short glitches and long assertions reach the synchroniser. It also includes a stretch with a tick on every cycle, which drives the total into saturation before a read clears it.

// File: rtl/therm_pkg.sv
package therm_pkg;
  typedef enum logic {
    ALERT_CUMULATIVE = 1'b0,
    ALERT_FIRST_HIT  = 1'b1
  } alert_mode_e;
endpackage

// File: rtl/therm_sync.sv
module therm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic active_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_n_i};
  end

  assign active_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/therm_accum.sv
module therm_accum #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             rd_i,
  output logic [ACC_W-1:0] total_o,
  output logic             seen_o
);
  localparam logic [ACC_W-1:0] SAT = '1;

  logic [ACC_W-1:0] total_q;
  logic             seen_q;
  logic             bump;

  assign bump = en_i && active_i && tick_i && (total_q != SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      seen_q  <= 1'b0;
    end else if (rd_i) begin
      total_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (bump)              total_q <= total_q + 1'b1;
      if (en_i && active_i)  seen_q  <= 1'b1;
    end
  end

  assign total_o = total_q;
  assign seen_o  = seen_q;

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (total_q == SAT && !rd_i) |=> total_q == SAT);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (total_q == '0 && !seen_q));
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !rd_i) |=> $stable(total_q));
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && total_q != SAT) |=> (total_q == $past(total_q) || total_q == $past(total_q) + 1'b1));
endmodule

// File: rtl/therm_alert_eval.sv
module therm_alert_eval
  import therm_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic [ACC_W-1:0] total_i,
  input  logic             seen_i,
  input  logic [ACC_W-1:0] limit_i,
  input  logic             mask_i,
  output logic             alert_o
);
  alert_mode_e mode;
  logic        raw;

  always_comb begin
    mode = (limit_i == '0) ? ALERT_FIRST_HIT : ALERT_CUMULATIVE;
    unique case (mode)
      ALERT_FIRST_HIT:  raw = seen_i;
      default:          raw = (total_i > limit_i);
    endcase
    alert_o = raw && !mask_i;
  end
endmodule

// File: rtl/fan_boost.sv
module fan_boost #(
  parameter int NUM_FANS = 4,
  parameter int DUTY_W   = 8
) (
  input  logic                       boost_i,
  input  logic                       active_i,
  input  logic [NUM_FANS*DUTY_W-1:0] duty_i,
  output logic [NUM_FANS*DUTY_W-1:0] duty_o
);
  localparam logic [DUTY_W-1:0] FULL = '1;

  for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
    logic [DUTY_W-1:0] din;
    logic              running;
    assign din     = duty_i[f*DUTY_W +: DUTY_W];
    assign running = (din != '0);
    assign duty_o[f*DUTY_W +: DUTY_W] = (boost_i && active_i && running) ? FULL : din;

    always_comb begin
      a_r10_never_lowers: assert (duty_o[f*DUTY_W +: DUTY_W] >= din);
    end
  end
endmodule

// File: rtl/therm_tally_top.sv
module therm_tally_top #(
  parameter int ACC_W    = 8,
  parameter int NUM_FANS = 4,
  parameter int DUTY_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       therm_n_i,
  input  logic                       tick_i,
  input  logic                       cfg_en_i,
  input  logic                       cfg_mask_i,
  input  logic                       cfg_boost_i,
  input  logic [ACC_W-1:0]           limit_i,
  input  logic                       rd_req_i,
  output logic [ACC_W-1:0]           rd_data_o,
  output logic                       alert_o,
  input  logic [NUM_FANS*DUTY_W-1:0] duty_in_i,
  output logic [NUM_FANS*DUTY_W-1:0] duty_out_o
);
  logic             active;
  logic [ACC_W-1:0] total;
  logic             seen;

  therm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n_i(therm_n_i), .active_o(active));

  therm_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .active_i(active), .en_i(cfg_en_i),
    .tick_i(tick_i), .rd_i(rd_req_i), .total_o(total), .seen_o(seen));

  therm_alert_eval #(.ACC_W(ACC_W)) u_alert (
    .total_i(total), .seen_i(seen), .limit_i(limit_i),
    .mask_i(cfg_mask_i), .alert_o(alert_o));

  fan_boost #(.NUM_FANS(NUM_FANS), .DUTY_W(DUTY_W)) u_boost (
    .boost_i(cfg_boost_i), .active_i(active),
    .duty_i(duty_in_i), .duty_o(duty_out_o));

  assign rd_data_o = total;

  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_n_i && $past(therm_n_i)) |=> !active);
  a_r8_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask_i |-> !alert_o);
endmodule

// File: tb/therm_tally_top_tb.sv
module therm_tally_top_tb;
  localparam int ACC_W = 8, NUM_FANS = 4, DUTY_W = 8;
  localparam int SATV = (1 << ACC_W) - 1;

  logic clk = 0, rst_n = 0;
  logic therm_n = 1, tick = 0, en = 0, mask = 0, boost = 0, rd = 0;
  logic [ACC_W-1:0] limit = '0;
  logic [ACC_W-1:0] rd_data;
  logic alert;
  logic [NUM_FANS*DUTY_W-1:0] din = '0, dout;

  int n_chk = 0, n_fail = 0;
  int seed_dummy;

  always #2.5 clk = ~clk;

  therm_tally_top #(.ACC_W(ACC_W), .NUM_FANS(NUM_FANS), .DUTY_W(DUTY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .therm_n_i(therm_n), .tick_i(tick),
    .cfg_en_i(en), .cfg_mask_i(mask), .cfg_boost_i(boost), .limit_i(limit),
    .rd_req_i(rd), .rd_data_o(rd_data), .alert_o(alert),
    .duty_in_i(din), .duty_out_o(dout));

  // reference model built from the requirements
  logic m_s1, m_s2, m_seen, m_act_chg, m_was_rd;
  int   m_acc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_acc <= 0; m_seen <= 0; m_act_chg <= 0; m_was_rd <= 0;
    end else begin
      m_s1 <= therm_n; m_s2 <= m_s1;
      m_act_chg <= (m_s1 != m_s2);
      m_was_rd <= rd;
      if (rd) begin
        m_acc <= 0; m_seen <= 0;
      end else begin
        if (en && !m_s2 && tick && m_acc != SATV) m_acc <= m_acc + 1;
        if (en && !m_s2) m_seen <= 1;
      end
    end
  end

  function automatic logic exp_alert();
    if (mask) return 1'b0;
    if (limit == 0) return m_seen;
    return (m_acc > int'(limit));
  endfunction

  function automatic logic [DUTY_W-1:0] exp_duty(logic [DUTY_W-1:0] d, logic act, logic b);
    return (b && act && d != 0) ? {DUTY_W{1'b1}} : d;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string ta, tl, td;
    if (!rst_n) ta = "R1";
    else if (m_was_rd) ta = "R5";
    else if (m_acc == SATV) ta = "R4";
    else ta = "R3";
    check(ta, int'(rd_data), m_acc);
    if (!rst_n) tl = "R1";
    else if (mask) tl = "R8";
    else if (limit == 0) tl = "R7";
    else tl = "R6";
    check(tl, int'(alert), int'(exp_alert()));
    for (int f = 0; f < NUM_FANS; f++) begin
      logic [DUTY_W-1:0] d;
      d = din[f*DUTY_W +: DUTY_W];
      if (!rst_n) td = "R1";
      else if (m_act_chg) td = "R2";
      else if (boost && !m_s2 && d != 0) td = "R9";
      else td = "R10";
      check(td, int'(dout[f*DUTY_W +: DUTY_W]), int'(exp_duty(d, !m_s2, boost)));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    int run;
    seed_dummy = $urandom(32'h5eed_7a11);
    din = {8'd0, 8'd90, 8'd1, 8'd200};
    boost = 1;
    #1;
    check_all();                       // R1 reset state
    @(negedge clk); check_all();
    rst_n = 1;
    step();

    // R7: first-event alert with zero limit
    en = 1; limit = 0;
    repeat (3) step();
    therm_n = 0;
    repeat (4) step();
    therm_n = 1;
    repeat (3) step();
    rd = 1; step(); rd = 0; step();    // R5 clears first-event flag

    // R4: saturation with a tick every cycle
    limit = 8'd8; therm_n = 0; tick = 1;
    repeat (SATV + 20) step();
    mask = 1; step(); mask = 0; step(); // R8
    rd = 1; step(); rd = 0;             // R5 read beats tick
    tick = 0; therm_n = 1;
    repeat (4) step();

    // R3: disabled timer holds total
    en = 0; therm_n = 0; tick = 1;
    repeat (6) step();
    en = 1; tick = 0; therm_n = 1;
    repeat (3) step();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if (run <= 0) begin
        therm_n = ~therm_n;
        run = 1 + ($urandom % 12);
      end
      run--;
      tick  = ($urandom % 3) == 0;
      rd    = ($urandom % 40) == 0;
      if (($urandom % 100) == 0) en    = ~en;
      if (($urandom % 80)  == 0) mask  = ~mask;
      if (($urandom % 60)  == 0) boost = ~boost;
      if (($urandom % 150) == 0) limit = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom % 40);
      if (($urandom % 30)  == 0) begin
        for (int f = 0; f < NUM_FANS; f++)
          din[f*DUTY_W +: DUTY_W] = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
      end
      step();
    end
    rd = 0; tick = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule